// File: doc/BRIEF.md
# Binary32 to Binary16 Float Narrowing Unit

This unit takes an IEEE-754 single-precision operand and returns the nearest half-precision value. It rounds to nearest with ties to even. It is a two-stage pipeline. The first stage splits the operand into sign, unbiased exponent and significand with the hidden one restored, and classifies it. The second stage shifts, rounds and packs the binary16 word. A new operand may be presented on every cycle, and each result appears exactly two cycles after its operand.

NaN handling depends on a per-operand mode bit. With the mode bit clear, the upper part of the NaN payload is carried into the half fraction and the result is made quiet. With the mode bit set, every NaN becomes one canonical quiet NaN. A signalling NaN input raises an invalid-operation flag alongside its result in either mode.

Top module: `f32_to_f16_narrow`

## Requirements
- R1: A zero operand, or any binary32 subnormal operand (exponent field 0), produces a half zero with the operand's sign: 0x0000 or 0x8000.
- R2: An infinite operand (exponent field 0xFF, fraction 0) produces 0x7C00 when positive and 0xFC00 when negative.
- R3: With `dflt_nan_i` low, a NaN operand (exponent field 0xFF, fraction nonzero) produces the operand sign in bit 15, ones in bits 14:10, a one in bit 9, and operand fraction bits 21:13 in result bits 8:0.
- R4: With `dflt_nan_i` high, every NaN operand produces 0x7E00, whatever its sign and payload.
- R5: `invalid_o` is high with a result exactly when the operand was a signalling NaN (operand bit 22 clear, nonzero fraction). This holds in both NaN modes. Quiet NaNs and non-NaN operands leave the flag low.
- R6: Operands whose unbiased exponent is in [-14, 15] produce a normal half. The 24-bit significand is rounded to 11 bits, nearest with ties to even. A carry out of the fraction raises the exponent, for example 0x3FFFF000 gives 0x4000.
- R7: Operands whose magnitude rounds above 65504 (0x7BFF) produce a signed infinity. This covers unbiased exponents above 15 and a rounding carry out of exponent 15. For example 0x477FF000 gives 0x7C00.
- R8: Operands with unbiased exponent below -14 are shifted right and then rounded on guard and sticky bits, giving a subnormal result. Ties go to even (0x33000000 gives 0x0000, 0x33C00000 gives 0x0002). A carry may reach the smallest normal 0x0400, and deep underflow gives a signed zero.
- R9: `out_valid_o` is low after reset, and it equals `in_valid_i` delayed by exactly two clock cycles.
- R10: Operands presented on consecutive cycles each produce their own result, in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand strobe |
| in_data_i | input | 32 | Binary32 operand |
| dflt_nan_i | input | 1 | When high, NaN operands produce the canonical quiet NaN |
| out_valid_o | output | 1 | Result strobe, two cycles after the operand strobe |
| out_data_o | output | 16 | Binary16 result |
| invalid_o | output | 1 | Invalid-operation flag, set for a signalling NaN operand |

## Verification
The bench builds the unit with the package defaults: a 24-bit source significand, 8-bit source exponent, 5-bit destination exponent and 10-bit destination fraction. With these widths a 25-bit shifter covers every rounding position. The random operands concentrate on biased exponents 100 to 159. That window spans deep underflow to zero, the subnormal band, the carry into 0x0400 and overflow past 65504, so the corners of R6 to R8 occur many times. Bursts with random gaps between them exercise back-to-back issue and the two-cycle strobe timing.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SRC_W      = 32;
  localparam int SRC_EXP_W  = 8;
  localparam int SRC_FRAC_W = 23;
  localparam int SRC_BIAS   = 127;
  localparam int DST_W      = 16;
  localparam int DST_EXP_W  = 5;
  localparam int DST_FRAC_W = 10;
  localparam int DST_BIAS   = 15;

  localparam int SIG_W     = SRC_FRAC_W + 1;
  localparam int FRAC_DROP = SRC_FRAC_W - DST_FRAC_W;
  localparam int EXP_W     = SRC_EXP_W + 2;
  localparam int SH_MAX    = SIG_W + 1;
  localparam int SH_W      = $clog2(SH_MAX + 1);

  localparam logic signed [EXP_W-1:0] DST_EMAX_S = EXP_W'(DST_BIAS);
  localparam logic signed [EXP_W-1:0] DST_EMIN_S = EXP_W'(1 - DST_BIAS);
  localparam logic signed [EXP_W-1:0] DEN_LIM_S  = EXP_W'(SH_MAX - FRAC_DROP);
  localparam logic signed [EXP_W-1:0] EXP_INF_S  = EXP_W'((1 << DST_EXP_W) - 1);

  localparam logic [DST_W-2:0] INF_MAG  = {{DST_EXP_W{1'b1}}, {DST_FRAC_W{1'b0}}};
  localparam logic [DST_W-1:0] DFLT_NAN = {1'b0, {DST_EXP_W{1'b1}}, 1'b1, {(DST_FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {K_FIN, K_ZERO, K_INF, K_NAN} kind_e;

  typedef struct packed {
    kind_e                   kind;
    logic                    sign;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
    logic                    snan;
    logic                    dflt_nan;
  } unp_t;
endpackage

// File: rtl/f2h_unpack.sv
module f2h_unpack
  import f2h_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SRC_W-1:0] data_i,
  input  logic             dflt_nan_i,
  output logic             valid_o,
  output unp_t             unp_o
);
  logic [SRC_EXP_W-1:0]    exp_f;
  logic [SRC_FRAC_W-1:0]   frac_f;
  logic signed [EXP_W-1:0] exp_ub;
  unp_t                    nxt;

  always_comb begin
    exp_f  = data_i[SRC_W-2 -: SRC_EXP_W];
    frac_f = data_i[SRC_FRAC_W-1:0];
    exp_ub = $signed({{(EXP_W-SRC_EXP_W){1'b0}}, exp_f}) - EXP_W'(SRC_BIAS);
    nxt          = '0;
    nxt.sign     = data_i[SRC_W-1];
    nxt.exp      = exp_ub;
    nxt.sig      = {1'b1, frac_f};
    nxt.dflt_nan = dflt_nan_i;
    if (exp_f == '1) begin
      if (frac_f == '0) nxt.kind = K_INF;
      else begin
        nxt.kind = K_NAN;
        nxt.snan = ~frac_f[SRC_FRAC_W-1];
      end
    end else if (exp_f == '0) begin
      nxt.kind = K_ZERO;  // binary32 subnormals lie far below half resolution
    end else if (exp_ub > DST_EMAX_S) begin
      nxt.kind = K_INF;
    end else begin
      nxt.kind = K_FIN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      unp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) unp_o <= nxt;
    end
  end

  // R5
  snan_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && unp_o.snan |-> unp_o.kind == K_NAN);
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic [DST_W-2:0]        mag_o
);
  localparam int XW = SIG_W + 1;

  logic                    subn;
  logic signed [EXP_W-1:0] deficit;
  logic signed [EXP_W-1:0] bexp;
  logic [SH_W-1:0]         sh;
  logic [XW-1:0]           sig_x, kept_v, grd_v, mask;
  logic                    guard, sticky, inc;
  logic [DST_FRAC_W+1:0]   rnd;

  always_comb begin
    subn    = exp_i < DST_EMIN_S;
    deficit = DST_EMIN_S - exp_i;
    if (!subn)                 sh = SH_W'(FRAC_DROP);
    else if (deficit >= DEN_LIM_S) sh = SH_W'(SH_MAX);
    else                       sh = SH_W'(FRAC_DROP) + SH_W'(deficit);
    sig_x  = {1'b0, sig_i};
    kept_v = sig_x >> sh;
    grd_v  = sig_x >> (sh - 1'b1);
    guard  = grd_v[0];
    mask   = (XW'(1) << (sh - 1'b1)) - XW'(1);
    sticky = |(sig_x & mask);
    inc    = guard & (sticky | kept_v[0]);
    rnd    = kept_v[DST_FRAC_W+1:0] + {{(DST_FRAC_W+1){1'b0}}, inc};
    bexp   = exp_i + EXP_W'(DST_BIAS) + {{(EXP_W-1){1'b0}}, rnd[DST_FRAC_W+1]};
    if (subn)                   mag_o = (DST_W-1)'(rnd[DST_FRAC_W:0]);  // carry lands in exponent LSB
    else if (bexp >= EXP_INF_S) mag_o = INF_MAG;
    else                        mag_o = {bexp[DST_EXP_W-1:0], rnd[DST_FRAC_W-1:0]};
  end
endmodule

// File: rtl/f2h_pack.sv
module f2h_pack
  import f2h_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  unp_t             unp_i,
  input  logic [DST_W-2:0] mag_i,
  output logic             valid_o,
  output logic [DST_W-1:0] data_o,
  output logic             invalid_o
);
  logic [DST_W-1:0] res;

  always_comb begin
    unique case (unp_i.kind)
      K_ZERO:  res = {unp_i.sign, {(DST_W-1){1'b0}}};
      K_INF:   res = {unp_i.sign, INF_MAG};
      K_NAN:   res = unp_i.dflt_nan ? DFLT_NAN :
                     {unp_i.sign, {DST_EXP_W{1'b1}}, 1'b1, unp_i.sig[SRC_FRAC_W-2 -: DST_FRAC_W-1]};
      default: res = {unp_i.sign, mag_i};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      invalid_o <= valid_i & unp_i.snan;
      if (valid_i) data_o <= res;
    end
  end

  // R5
  inv_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> valid_o);
  // R3
  nan_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && unp_i.kind == K_NAN |=>
      data_o[DST_FRAC_W-1] && (data_o[DST_W-2 -: DST_EXP_W] == '1));
  // R6
  no_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && unp_i.kind != K_NAN |=>
      !((data_o[DST_W-2 -: DST_EXP_W] == '1) && (data_o[DST_FRAC_W-1:0] != '0)));
endmodule

// File: rtl/f32_to_f16_narrow.sv
module f32_to_f16_narrow
  import f2h_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [SRC_W-1:0] in_data_i,
  input  logic             dflt_nan_i,
  output logic             out_valid_o,
  output logic [DST_W-1:0] out_data_o,
  output logic             invalid_o
);
  logic             s1_valid;
  unp_t             s1_unp;
  logic [DST_W-2:0] s1_mag;

  f2h_unpack u_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .data_i     (in_data_i),
    .dflt_nan_i (dflt_nan_i),
    .valid_o    (s1_valid),
    .unp_o      (s1_unp)
  );

  f2h_round u_round (
    .exp_i (s1_unp.exp),
    .sig_i (s1_unp.sig),
    .mag_o (s1_mag)
  );

  f2h_pack u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (s1_valid),
    .unp_i     (s1_unp),
    .mag_i     (s1_mag),
    .valid_o   (out_valid_o),
    .data_o    (out_data_o),
    .invalid_o (invalid_o)
  );

  // R9
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 out_valid_o);
  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !out_valid_o);
endmodule

// File: tb/f32_to_f16_narrow_bench.sv
`timescale 1ns/1ps
module f32_to_f16_narrow_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        dflt_nan;
  logic        out_valid;
  logic [15:0] out_data;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [15:0] q_data[$];
  logic        q_inv[$];
  int          q_due[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  f32_to_f16_narrow u_f32_to_f16_narrow (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .dflt_nan_i(dflt_nan), .out_valid_o(out_valid), .out_data_o(out_data),
    .invalid_o(invalid));

  function automatic int rne(real q);
    real f = $floor(q);
    int n = $rtoi(f);
    real d = q - f;
    if (d > 0.5 || (d == 0.5 && (n % 2) == 1)) n++;
    return n;
  endfunction

  task automatic model(input logic [31:0] x, input logic dn,
                       output logic [15:0] r, output logic inv);
    logic s = x[31];
    int ex = int'(x[30:23]);
    logic [22:0] fr = x[22:0];
    int e, n;
    real sig;
    inv = 1'b0;
    if (ex == 255 && fr != 0) begin
      inv = ~fr[22];
      r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, fr[21:13]};
    end else if (ex == 255) r = {s, 15'h7C00};
    else if (ex == 0) r = {s, 15'h0000};
    else begin
      e = ex - 127;
      sig = 8388608.0 + real'(fr);
      if (e < -14) begin
        n = rne(sig * (2.0 ** (e + 1)));
        r = {s, 15'(n)};
      end else begin
        n = rne(sig / 8192.0);
        if (n == 2048) begin n = 1024; e = e + 1; end
        if (e > 15) r = {s, 15'h7C00};
        else r = {s, 5'(e + 15), 10'(n)};
      end
    end
  endtask

  task automatic push(input logic [31:0] x, input logic dn,
                      input logic [15:0] r, input logic inv, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; dflt_nan = dn;
    q_data.push_back(r); q_inv.push_back(inv);
    q_due.push_back(cyc + 2); q_tag.push_back(tag);
  endtask

  task automatic send(input logic [31:0] x, input logic dn,
                      input logic [15:0] r, input logic inv, input string tag);
    push(x, dn, r, inv, tag);
  endtask

  task automatic send_rand(input logic [31:0] x, input logic dn);
    logic [15:0] r; logic inv;
    model(x, dn, r, inv);
    push(x, dn, r, inv, "R6 R7 R8 R10 sweep");
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); in_valid = 1'b0; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (q_data.size() == 0) begin
          failures++;
          $display("FAIL R9: got unexpected result %h at cyc %0d, expected no strobe", out_data, cyc);
        end else begin
          if (out_data !== q_data[0] || invalid !== q_inv[0] || cyc != q_due[0]) begin
            failures++;
            $display("FAIL %s: got data=%h inv=%b cyc=%0d, expected data=%h inv=%b cyc=%0d",
                     q_tag[0], out_data, invalid, cyc, q_data[0], q_inv[0], q_due[0]);
          end
          void'(q_data.pop_front()); void'(q_inv.pop_front());
          void'(q_due.pop_front());  void'(q_tag.pop_front());
        end
      end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
        checks++; failures++;
        $display("FAIL R9 %s: got no strobe at cyc %0d, expected data=%h", q_tag[0], cyc, q_data[0]);
        void'(q_data.pop_front()); void'(q_inv.pop_front());
        void'(q_due.pop_front());  void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung run, expected drained queue");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; dflt_nan = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || invalid !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset: got valid=%b inv=%b, expected 0 0", out_valid, invalid);
    end
    rst_n = 1'b1;
    idle(2);
    // R1
    send(32'h0000_0000, 0, 16'h0000, 0, "R1 +zero");
    send(32'h8000_0000, 0, 16'h8000, 0, "R1 -zero");
    send(32'h0000_0001, 0, 16'h0000, 0, "R1 subnormal in");
    send(32'h8040_0000, 1, 16'h8000, 0, "R1 -subnormal in");
    // R2
    send(32'h7F80_0000, 0, 16'h7C00, 0, "R2 +inf");
    send(32'hFF80_0000, 1, 16'hFC00, 0, "R2 -inf");
    idle(1);
    // R3, R5
    send(32'h7FC0_2000, 0, 16'h7E01, 0, "R3 qnan payload");
    send(32'hFF80_2000, 0, 16'hFE01, 1, "R3 R5 snan payload");
    send(32'h7F80_0001, 0, 16'h7E00, 1, "R5 snan low payload");
    // R4
    send(32'hFFC1_2345, 1, 16'h7E00, 0, "R4 dflt qnan");
    send(32'hFF80_0001, 1, 16'h7E00, 1, "R4 R5 dflt snan");
    idle(2);
    // R6
    send(32'h3F80_0000, 0, 16'h3C00, 0, "R6 one");
    send(32'h3F80_1000, 0, 16'h3C00, 0, "R6 tie even down");
    send(32'h3F80_3000, 0, 16'h3C02, 0, "R6 tie odd up");
    send(32'h3F80_1001, 0, 16'h3C01, 0, "R6 above half");
    send(32'h3FFF_F000, 0, 16'h4000, 0, "R6 carry exponent");
    send(32'hBF80_0000, 0, 16'hBC00, 0, "R6 minus one");
    // R7
    send(32'h477F_E000, 0, 16'h7BFF, 0, "R7 max finite");
    send(32'h477F_EFFF, 0, 16'h7BFF, 0, "R7 below tie");
    send(32'h477F_F000, 0, 16'h7C00, 0, "R7 tie to inf");
    send(32'h47C3_5000, 0, 16'h7C00, 0, "R7 large");
    send(32'hC780_0000, 0, 16'hFC00, 0, "R7 -65536");
    // R8
    send(32'h3380_0000, 0, 16'h0001, 0, "R8 min subnormal");
    send(32'h3300_0000, 0, 16'h0000, 0, "R8 tie to zero");
    send(32'h3300_0001, 0, 16'h0001, 0, "R8 above tie");
    send(32'h33C0_0000, 0, 16'h0002, 0, "R8 tie odd up");
    send(32'h3800_0000, 0, 16'h0200, 0, "R8 2^-15");
    send(32'h387F_F800, 0, 16'h0400, 0, "R8 carry to normal");
    send(32'h3880_0000, 0, 16'h0400, 0, "R8 min normal");
    send(32'hAA00_0000, 0, 16'h8000, 0, "R8 deep underflow");
    idle(3);
    // R10 bursts with gaps
    for (int i = 0; i < 1600; i++) begin
      logic [31:0] x;
      x = $urandom;
      if ((i % 8) != 7) x[30:23] = 8'(100 + ($urandom % 60));
      send_rand(x, 1'($urandom % 2));
      if (($urandom % 5) == 0) idle(1 + ($urandom % 2));
    end
    idle(1);
    for (int i = 0; i < 100 && q_data.size() != 0; i++) @(negedge clk);
    idle(2);
    finish_run();
  end
endmodule